// File: doc/BRIEF.md
# Paged Instruction-Address Sequencer with Return-Frame Stack

This block produces the fetch address for a small 8-bit controller core. It keeps a 14-bit program address split into an 8-bit offset and a 6-bit page. Ordinary fetch advances only the offset, by one or two bytes per instruction. When the offset passes 0xFF it wraps to the start of the same page. The page moves only on an explicit page-advance request. A jump loads all 14 bits of a target in one cycle.

A call or interrupt acknowledge saves a two-byte return frame into data SRAM through a byte port, then continues at the supplied target. The frame holds the current address and the carry and zero flags. Plain return and flag-restoring return read the frame back. Only the flag-restoring return hands the saved flags back to the core, through a one-cycle strobe. The frame stack starts at SRAM byte 0x00 and grows upward. The core must hold fetch while `busy` is high. The block also flags any address inside the 32 reserved bytes at the top of the 8 KB program space.

Top module: `paged_pc_seq`

## Requirements
- R1: After a synchronous active-low reset, `pc` is 0x0000, `busy`, `mem_we`, `mem_re` and `flag_we` are low, and the first frame is written at SRAM address 0x00.
- R2: An accepted `fetch_adv` adds 1 to `pc[7:0]` when `adv_two` is 0, or 2 when `adv_two` is 1. The sum is taken modulo 256, and `pc[13:8]` is unchanged. The new value is visible after the next clock edge.
- R3: An accepted `page_adv` adds 1 to `pc[13:8]` modulo 64 and leaves `pc[7:0]` unchanged.
- R4: An accepted `jump_req` loads all 14 bits of `target` into `pc` at the next edge.
- R5: An accepted `call_req` or `irq_ack` loads `target` into `pc` at the accepting edge. In the two cycles that follow it writes two bytes. The first goes to address SP and is {carry_in in bit 7, zero_in in bit 6, old pc[13:8] in bits 5:0}. The second goes to SP+1 and is old pc[7:0]. `mem_we` and `mem_re` are never high together.
- R6: `busy` is high for exactly the two cycles after a call or return is accepted. Requests that arrive while `busy` is high are ignored, and `pc` holds its value between the two busy cycles.
- R7: An accepted `ret_req` reads address SP-1 (offset byte) and then SP-2 (flag/page byte). After the second read, `pc` becomes {page byte bits 5:0, offset byte}. `flag_we` stays low.
- R8: An accepted `reti_req` behaves like R7. In the cycle in which the new `pc` appears, it also pulses `flag_we` for one cycle with `carry_out` equal to bit 7 and `zero_out` equal to bit 6 of the page byte.
- R9: Nested calls place their frames at SRAM addresses 0, 2, 4 and so on. Returns take the frames back in reverse order and restore SP.
- R10: `fetch_fault` is high exactly when `pc` is 0x1FE0 or above.
- R11: When several requests arrive in one idle cycle, only one is accepted. The order is call or interrupt acknowledge first, then return (flag-restoring return when both return kinds are requested), then jump, then page advance, then fetch advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_adv | input | 1 | An instruction was fetched; advance the offset |
| adv_two | input | 1 | Length of that instruction: 0 = one byte, 1 = two bytes |
| page_adv | input | 1 | Page-advance instruction executed |
| jump_req | input | 1 | Load `target` into the address |
| call_req | input | 1 | Subroutine call to `target` |
| irq_ack | input | 1 | Interrupt acknowledge; vector on `target` |
| ret_req | input | 1 | Return that restores the address only |
| reti_req | input | 1 | Return that restores the address and the flags |
| target | input | 14 | Jump, call or vector address |
| carry_in | input | 1 | Current carry flag, saved on a call |
| zero_in | input | 1 | Current zero flag, saved on a call |
| mem_rdata | input | 8 | SRAM read data, valid in the cycle `mem_addr` is presented |
| pc | output | 14 | Current fetch address |
| busy | output | 1 | Frame transfer in progress; fetch must stall |
| fetch_fault | output | 1 | `pc` lies in the reserved top 32 bytes or above |
| mem_we | output | 1 | SRAM byte write strobe |
| mem_re | output | 1 | SRAM byte read strobe |
| mem_addr | output | 8 | SRAM byte address (stack slot) |
| mem_wdata | output | 8 | SRAM write data |
| flag_we | output | 1 | One-cycle strobe to restore the core flags |
| carry_out | output | 1 | Carry value to restore |
| zero_out | output | 1 | Zero value to restore |

## Verification
A wrong offset or page register shows up on `pc` one edge after the offending request. The offset-wrap and page-wrap sweeps therefore catch a carry leaking between the two fields at the exact step where it happens. A stack pointer off by one shows up on `mem_addr` in the first busy cycle of the next call or return, and later as a wrong return address or wrong restored flags. A frame-state machine that sticks or skips a state shows up as a `busy` window other than two cycles, or as a request that is accepted while busy.

// File: rtl/pcseq_pkg.sv
// Shared widths and types for the paged address sequencer.
// Assumes one SRAM byte holds the two flags plus one page number.
package pcseq_pkg;
    localparam int PC_W   = 14;
    localparam int LO_W   = 8;
    localparam int PG_W   = PC_W - LO_W;
    localparam int BYTE_W = PG_W + 2;
    localparam int SP_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_POP_LO,
        ST_POP_HI
    } frame_st_t;

    typedef struct packed {
        logic            carry;
        logic            zero;
        logic [PG_W-1:0] page;
    } frame_hi_t;
endpackage

// File: rtl/pcseq_pc_reg.sv
// Program address register, split into an offset field and a page field.
// A load wins over a page advance, and a page advance wins over an offset step.
// Offset steps wrap inside the page and never carry into the page field.
module pcseq_pc_reg
    import pcseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [PC_W-1:0] load_val,
    input  logic            page_inc,
    input  logic            step_en,
    input  logic            step_two,
    output logic [PC_W-1:0] pc
);
    logic [LO_W-1:0] lo_q, lo_d;
    logic [PG_W-1:0] pg_q, pg_d;

    // Choose the next offset and page.
    always_comb begin
        lo_d = lo_q;
        pg_d = pg_q;
        if (load_en) begin
            {pg_d, lo_d} = load_val;
        end else if (page_inc) begin
            pg_d = pg_q + 1'b1;
        end else if (step_en) begin
            lo_d = lo_q + (step_two ? LO_W'(2) : LO_W'(1));
        end
    end

    // Register both fields; reset points at address zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            pg_q <= '0;
        end else begin
            lo_q <= lo_d;
            pg_q <= pg_d;
        end
    end

    assign pc = {pg_q, lo_q};
endmodule

// File: rtl/pcseq_frame_ctl.sv
// Return-frame engine: writes a two-byte frame on a call and reads it back on a return.
// Assumes the SRAM returns read data in the same cycle as the address (asynchronous read).
// The stack pointer increments after each write and decrements before each read.
module pcseq_frame_ctl
    import pcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_go,
    input  logic              pop_go,
    input  logic              pop_flags,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic              carry_in,
    input  logic              zero_in,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_re,
    output logic [SP_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              pop_load,
    output logic [PC_W-1:0]   pop_addr,
    output logic              flag_we,
    output logic              carry_out,
    output logic              zero_out
);
    frame_st_t       st;
    logic [SP_W-1:0] sp;
    frame_hi_t       hold_hi;
    logic [LO_W-1:0] hold_lo;
    logic            want_flags;
    frame_hi_t       rd_hi;

    assign rd_hi = frame_hi_t'(mem_rdata);

    // Sequence the frame states and move the stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            sp         <= '0;
            hold_hi    <= '0;
            hold_lo    <= '0;
            want_flags <= 1'b0;
            flag_we    <= 1'b0;
            carry_out  <= 1'b0;
            zero_out   <= 1'b0;
        end else begin
            flag_we <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (push_go) begin
                        hold_hi <= '{carry: carry_in, zero: zero_in,
                                     page: ret_addr[PC_W-1:LO_W]};
                        hold_lo <= ret_addr[LO_W-1:0];
                        st      <= ST_PUSH_HI;
                    end else if (pop_go) begin
                        sp         <= sp - 1'b1;
                        want_flags <= pop_flags;
                        st         <= ST_POP_LO;
                    end
                end
                ST_PUSH_HI: begin
                    sp <= sp + 1'b1;
                    st <= ST_PUSH_LO;
                end
                ST_PUSH_LO: begin
                    sp <= sp + 1'b1;
                    st <= ST_IDLE;
                end
                ST_POP_LO: begin
                    hold_lo <= mem_rdata;
                    sp      <= sp - 1'b1;
                    st      <= ST_POP_HI;
                end
                ST_POP_HI: begin
                    if (want_flags) begin
                        flag_we   <= 1'b1;
                        carry_out <= rd_hi.carry;
                        zero_out  <= rd_hi.zero;
                    end
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Drive the SRAM port from the current state.
    always_comb begin
        mem_we    = (st == ST_PUSH_HI) || (st == ST_PUSH_LO);
        mem_re    = (st == ST_POP_LO) || (st == ST_POP_HI);
        mem_addr  = sp;
        mem_wdata = (st == ST_PUSH_HI) ? BYTE_W'(hold_hi) : hold_lo;
    end

    assign busy     = (st != ST_IDLE);
    assign pop_load = (st == ST_POP_HI);
    assign pop_addr = {rd_hi.page, hold_lo};
endmodule

// File: rtl/paged_pc_seq.sv
// Top of the paged address sequencer. It arbitrates the incoming requests,
// steers the address register, and starts frame transfers.
// Assumes the core holds fetch while busy; requests that arrive while busy are dropped.
module paged_pc_seq
    import pcseq_pkg::*;
#(
    parameter int ROM_BYTES = 8192,
    parameter int RSV_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_adv,
    input  logic              adv_two,
    input  logic              page_adv,
    input  logic              jump_req,
    input  logic              call_req,
    input  logic              irq_ack,
    input  logic              ret_req,
    input  logic              reti_req,
    input  logic [PC_W-1:0]   target,
    input  logic              carry_in,
    input  logic              zero_in,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [PC_W-1:0]   pc,
    output logic              busy,
    output logic              fetch_fault,
    output logic              mem_we,
    output logic              mem_re,
    output logic [SP_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              flag_we,
    output logic              carry_out,
    output logic              zero_out
);
    localparam logic [PC_W-1:0] RSV_BASE = PC_W'(ROM_BYTES - RSV_BYTES);

    logic            idle, call_any, ret_any;
    logic            push_go, pop_go, jmp_go, pg_go, step_go;
    logic            pop_load;
    logic [PC_W-1:0] pop_addr;
    logic            load_en;
    logic [PC_W-1:0] load_val;

    // Fixed-priority arbitration of the requests, only while idle.
    always_comb begin
        idle     = !busy;
        call_any = call_req | irq_ack;
        ret_any  = ret_req | reti_req;
        push_go  = idle & call_any;
        pop_go   = idle & !call_any & ret_any;
        jmp_go   = idle & !call_any & !ret_any & jump_req;
        pg_go    = idle & !call_any & !ret_any & !jump_req & page_adv;
        step_go  = idle & !call_any & !ret_any & !jump_req & !page_adv & fetch_adv;
        load_en  = push_go | jmp_go | pop_load;
        load_val = pop_load ? pop_addr : target;
    end

    pcseq_pc_reg u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_val (load_val),
        .page_inc (pg_go),
        .step_en  (step_go),
        .step_two (adv_two),
        .pc       (pc)
    );

    pcseq_frame_ctl u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_go   (push_go),
        .pop_go    (pop_go),
        .pop_flags (reti_req),
        .ret_addr  (pc),
        .carry_in  (carry_in),
        .zero_in   (zero_in),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pop_load  (pop_load),
        .pop_addr  (pop_addr),
        .flag_we   (flag_we),
        .carry_out (carry_out),
        .zero_out  (zero_out)
    );

    assign fetch_fault = (pc >= RSV_BASE);
endmodule

// File: rtl/paged_pc_seq_chk.sv
// Timing checks on the sequencer ports, bound to every instance of the top module.
// Assumes that rst_n is held low for at least one clock edge at start-up.
module paged_pc_seq_chk
    import pcseq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_adv,
    input logic            page_adv,
    input logic            jump_req,
    input logic            call_req,
    input logic            irq_ack,
    input logic            ret_req,
    input logic            reti_req,
    input logic [PC_W-1:0] pc,
    input logic            busy,
    input logic            mem_we,
    input logic            mem_re,
    input logic [SP_W-1:0] mem_addr,
    input logic            flag_we
);
    logic run_q;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re)); // R6
    AST_BUSY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && busy && $past(busy)) |=> !busy); // R6
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && busy && $past(busy)) |-> $stable(pc)); // R6
    AST_STEP_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fetch_adv && !page_adv && !jump_req && !call_req && !irq_ack
         && !ret_req && !reti_req) |=> (pc[PC_W-1:LO_W] == $past(pc[PC_W-1:LO_W]))); // R2
    AST_FLAG_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && flag_we) |-> $past(mem_re)); // R8
    AST_PUSH_UPWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R9
endmodule

bind paged_pc_seq paged_pc_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_adv (fetch_adv),
    .page_adv  (page_adv),
    .jump_req  (jump_req),
    .call_req  (call_req),
    .irq_ack   (irq_ack),
    .ret_req   (ret_req),
    .reti_req  (reti_req),
    .pc        (pc),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .flag_we   (flag_we)
);

// File: tb/paged_pc_seq_test.sv
// Self-checking bench: sweeps offset and page wraps, jumps, nested call/return frames,
// flag restore, request priority and the reserved-range flag.
module paged_pc_seq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_adv, adv_two, page_adv, jump_req, call_req, irq_ack, ret_req, reti_req;
    logic [13:0] target;
    logic        carry_in, zero_in;
    logic [7:0]  mem_rdata;
    logic [13:0] pc;
    logic        busy, fetch_fault, mem_we, mem_re, flag_we, carry_out, zero_out;
    logic [7:0]  mem_addr, mem_wdata;

    logic [7:0]  smem [256];
    int          n_chk = 0;
    int          n_fail = 0;
    int          exp_sp = 0;

    always #4 clk = ~clk;

    paged_pc_seq uut (
        .clk(clk), .rst_n(rst_n), .fetch_adv(fetch_adv), .adv_two(adv_two),
        .page_adv(page_adv), .jump_req(jump_req), .call_req(call_req), .irq_ack(irq_ack),
        .ret_req(ret_req), .reti_req(reti_req), .target(target), .carry_in(carry_in),
        .zero_in(zero_in), .mem_rdata(mem_rdata), .pc(pc), .busy(busy),
        .fetch_fault(fetch_fault), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .flag_we(flag_we), .carry_out(carry_out), .zero_out(zero_out)
    );

    // Data SRAM model: asynchronous read, write on the clock edge.
    assign mem_rdata = smem[mem_addr];
    always @(posedge clk) if (mem_we) smem[mem_addr] <= mem_wdata;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        fetch_adv = 0; adv_two = 0; page_adv = 0; jump_req = 0;
        call_req = 0; irq_ack = 0; ret_req = 0; reti_req = 0;
    endtask

    task automatic do_jump(input logic [13:0] t);
        jump_req = 1; target = t;
        step();
        jump_req = 0;
    endtask

    task automatic do_call(input logic [13:0] t, input bit c, input bit z, input bit use_irq);
        logic [13:0] old;
        logic [7:0]  hi;
        old = pc;
        hi  = {c, z, old[13:8]};
        if (use_irq) irq_ack = 1; else call_req = 1;
        target = t; carry_in = c; zero_in = z;
        step();
        idle_in();
        chk("R5 pc takes target", pc, t);
        chk("R6 busy first", busy, 1);
        chk("R5 we first", mem_we, 1);
        chk("R9 addr first", mem_addr, exp_sp & 255);
        chk("R5 flag/page byte", mem_wdata, hi);
        step();
        chk("R5 we second", mem_we, 1);
        chk("R9 addr second", mem_addr, (exp_sp + 1) & 255);
        chk("R5 offset byte", mem_wdata, old[7:0]);
        step();
        chk("R6 busy ends", busy, 0);
        chk("R9 frame hi stored", smem[exp_sp & 255], hi);
        exp_sp = exp_sp + 2;
    endtask

    task automatic do_ret(input bit with_flags, input logic [13:0] exp_pc, input bit c, input bit z);
        if (with_flags) reti_req = 1; else ret_req = 1;
        step();
        idle_in();
        chk("R7 read first", mem_re, 1);
        chk("R7 addr first", mem_addr, (exp_sp - 1) & 255);
        chk("R8 no early flag", flag_we, 0);
        step();
        chk("R7 read second", mem_re, 1);
        chk("R7 addr second", mem_addr, (exp_sp - 2) & 255);
        step();
        chk("R6 busy ends", busy, 0);
        chk("R7 pc restored", pc, exp_pc);
        chk(with_flags ? "R8 flag strobe" : "R7 no flag strobe", flag_we, with_flags);
        if (with_flags) begin
            chk("R8 carry restored", carry_out, c);
            chk("R8 zero restored", zero_out, z);
        end
        step();
        chk("R8 strobe one cycle", flag_we, 0);
        exp_sp = exp_sp - 2;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [13:0] exp_pc;
        for (int i = 0; i < 256; i++) smem[i] = 8'h00;
        idle_in();
        target = 0; carry_in = 0; zero_in = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 pc reset", pc, 0);
        chk("R1 busy reset", busy, 0);
        chk("R1 we reset", mem_we, 0);
        chk("R1 re reset", mem_re, 0);
        chk("R1 flag reset", flag_we, 0);

        // R4: jump sweep over scattered targets
        for (int i = 0; i < 12; i++) begin
            logic [13:0] t;
            t = 14'((i * 14'h0ABD + 14'h0123) & 14'h3FFF);
            do_jump(t);
            chk("R4 jump load", pc, t);
        end

        // R2: offset stepping with mixed lengths, wrapping inside page 0x2A
        do_jump(14'h2AF0);
        exp_pc = 14'h2AF0;
        for (int i = 0; i < 300; i++) begin
            fetch_adv = 1; adv_two = (i % 3 == 2);
            step();
            exp_pc[7:0] = exp_pc[7:0] + ((i % 3 == 2) ? 8'd2 : 8'd1);
            chk("R2 offset step", pc, exp_pc);
        end
        idle_in();

        // R3: page advance sweep through the 64-page wrap
        do_jump(14'h3A5A);
        exp_pc = 14'h3A5A;
        for (int i = 0; i < 70; i++) begin
            page_adv = 1;
            step();
            exp_pc[13:8] = exp_pc[13:8] + 6'd1;
            chk("R3 page step", pc, exp_pc);
        end
        idle_in();

        // R10: reserved-range boundaries
        do_jump(14'h1FDF); chk("R10 below reserved", fetch_fault, 0);
        do_jump(14'h1FE0); chk("R10 reserved start", fetch_fault, 1);
        do_jump(14'h1FFF); chk("R10 reserved end", fetch_fault, 1);
        do_jump(14'h0100); chk("R10 normal range", fetch_fault, 0);

        // R9/R5/R7/R8: nested frames and reverse-order returns
        do_jump(14'h0123);
        do_call(14'h0800, 1, 0, 0);
        do_call(14'h1234, 0, 1, 1);
        do_call(14'h0555, 1, 1, 0);
        chk("R9 third frame hi", smem[4], 8'hD2);
        do_ret(1, 14'h1234, 1, 1);
        do_ret(0, 14'h0800, 1, 1);
        chk("R7 flags untouched", carry_out, 1);
        do_ret(1, 14'h0123, 1, 0);
        chk("R9 sp back to base", exp_sp, 0);

        // R8: flag restore over all four flag combinations
        for (int f = 0; f < 4; f++) begin
            do_jump(14'(14'h0A00 + f));
            do_call(14'h0300, f[1], f[0], f[0]);
            do_ret(1, 14'(14'h0A00 + f), f[1], f[0]);
        end

        // R6: requests during a frame transfer are dropped
        do_jump(14'h0040);
        call_req = 1; target = 14'h0600;
        step();
        call_req = 0; jump_req = 1; fetch_adv = 1; target = 14'h0777;
        step();
        page_adv = 1;
        step();
        idle_in();
        chk("R6 busy window closed", busy, 0);
        chk("R6 pc ignores busy requests", pc, 14'h0600);
        exp_sp = exp_sp + 2;
        do_ret(0, 14'h0040, 0, 0);

        // R11: priority between simultaneous requests
        do_jump(14'h0210);
        page_adv = 1; fetch_adv = 1;
        step(); idle_in();
        chk("R11 page beats step", pc, 14'h0310);
        jump_req = 1; page_adv = 1; fetch_adv = 1; target = 14'h0999;
        step(); idle_in();
        chk("R11 jump beats page", pc, 14'h0999);
        do_call(14'h0C00, 0, 0, 0);
        ret_req = 1; jump_req = 1; target = 14'h0111;
        step(); idle_in();
        chk("R11 return beats jump", mem_re, 1);
        step(); step();
        chk("R11 return result", pc, 14'h0999);
        exp_sp = exp_sp - 2;
        call_req = 1; ret_req = 1; target = 14'h0AB0;
        step(); idle_in();
        chk("R11 call beats return", mem_we, 1);
        step(); step();
        exp_sp = exp_sp + 2;
        ret_req = 1; reti_req = 1;
        step(); idle_in();
        step(); step();
        chk("R11 flag return wins", flag_we, 1);
        chk("R11 pc after", pc, 14'h0999);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule